// File: doc/BRIEF.md
# Packet Channel Handshake Controller

This block is the controller-side sequencer for a packet channel carried over a byte-wide mailbox. Once local setup of the shared control area is done, it announces itself through the mailbox status register. It then waits for the host's Initialise command, settles on a protocol version and the packet size limits in each direction, and marks the channel live. After that it manages which side owns the shared receive buffer and which side owns the shared transmit buffer.

Every command byte and every status change goes out through the output data register. A status register write does not interrupt the host by itself, so each one is followed by a filler byte 0xFF on the data register. Writes are never issued while the host has not yet read the previous byte. Pending outgoing items are held and sent in a fixed priority order. For protocol version 3 the block also checks a CRC-32 over the bytes that local logic reads out of the receive buffer.

Top module: `pkt_chan_ctrl`

## Requirements
- R1: After reset, str_we, odr_we, rx_own, tx_own, proto_err, crc_fail and neg_ver are all 0.
- R2: While area_ready is high after reset, the block performs one status update with value 0x80 (bit 7 = controller active, bit 6 = channel active, other bits 0).
- R3: On command 0x00 (Initialise), the negotiated version is the highest value inside both [host_vmin, host_vmax] and [VER_MIN, VER_MAX] (defaults 1..3). The block then performs a status update with value 0xC0.
- R4: If the two version ranges share no value, neg_ver reads 0, the channel stays inactive and no status update is sent.
- R5: With version 1 both sizes equal BTU (64). With version 2 or 3, mtu_to_host is host_rx_sz clamped into [BTU, BUF_SIZE] (64..256) and mtu_from_host is BUF_SIZE.
- R6: Command 0x01 (Tx Begin) on a live channel sets rx_own. A later rx_done clears rx_own and queues 0x02 (Rx Complete) for the host.
- R7: While tx_req is high on a live channel, tx_own is granted only when no earlier 0x01 is still awaiting the host's 0x02. tx_filled clears tx_own and queues 0x01.
- R8: No data register write is issued while obf is high. Two data register writes are never on consecutive cycles, and blocked items stay queued.
- R9: A status register write is always followed on the next cycle by a data register write of 0xFF.
- R10: 0x01 or 0x02 before the channel is live, 0x02 with nothing outstanding, 0x00 before area_ready, or an undefined code sets proto_err permanently and changes no ownership. 0xFF from the host is ignored.
- R11: At rx_done under version 3, crc_fail is set when rx_crc differs from the CRC-32 of the streamed bytes. That CRC uses reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF and final inversion. crc_fail stays 0 under other versions.
- R12: When several items are queued, a status update goes first, then 0x02, then 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| area_ready | input | 1 | Local setup of the control area is complete |
| cmd_valid | input | 1 | A host command byte was taken from the mailbox |
| cmd_byte | input | 8 | Host command code |
| host_vmin | input | VER_W | Lowest version the host supports |
| host_vmax | input | VER_W | Highest version the host supports |
| host_rx_sz | input | SZ_W | Receive packet size the host proposes |
| obf | input | 1 | Output data register still unread by host |
| tx_req | input | 1 | Local logic has a packet to send |
| tx_filled | input | 1 | Local logic finished writing the transmit buffer |
| rx_done | input | 1 | Local logic finished reading the receive buffer |
| rx_byte_vld | input | 1 | Packet byte read from the receive buffer |
| rx_byte | input | 8 | Packet byte value |
| rx_crc | input | 32 | CRC carried with the received packet |
| str_we | output | 1 | Status register write strobe |
| str_data | output | 8 | Status register value |
| odr_we | output | 1 | Output data register write strobe |
| odr_data | output | 8 | Output data register value |
| neg_ver | output | VER_W | Negotiated version, 0 when none |
| mtu_to_host | output | SZ_W | Packet size limit toward the host |
| mtu_from_host | output | SZ_W | Packet size limit from the host |
| rx_own | output | 1 | Local logic owns the receive buffer |
| tx_own | output | 1 | Local logic may write the transmit buffer |
| proto_err | output | 1 | Sticky protocol error |
| crc_fail | output | 1 | Last received packet failed its CRC |

## Verification
The receive release and the transmit hand-off can land in the same cycle, and a re-sent Initialise can queue a status update next to them. The bench holds obf high and issues a second Initialise. It then pulses rx_done and tx_filled on the same edge. While obf stays high it confirms that nothing leaves the data register. After releasing obf, it expects the recorded write stream to read status 0xC0, filler 0xFF, 0x02, 0x01 in that order.

// File: rtl/pkt_chan_pkg.sv
package pkt_chan_pkg;
  typedef enum logic [1:0] {ST_OFF, ST_WAIT, ST_RUN} ch_state_e;
  localparam logic [7:0] CMD_INIT  = 8'h00;
  localparam logic [7:0] CMD_TXBEG = 8'h01;
  localparam logic [7:0] CMD_RXCMP = 8'h02;
  localparam logic [7:0] CMD_DUMMY = 8'hFF;
  localparam int STAT_CTL_BIT  = 7;
  localparam int STAT_CHAN_BIT = 6;
endpackage

// File: rtl/pkt_chan_vneg.sv
module pkt_chan_vneg #(
  parameter int VER_W    = 4,
  parameter int VER_MIN  = 1,
  parameter int VER_MAX  = 3,
  parameter int SZ_W     = 16,
  parameter int BTU      = 64,
  parameter int BUF_SIZE = 256
) (
  input  logic [VER_W-1:0] host_vmin,
  input  logic [VER_W-1:0] host_vmax,
  input  logic [SZ_W-1:0]  host_rx_sz,
  output logic             ok,
  output logic [VER_W-1:0] ver,
  output logic [SZ_W-1:0]  mtu_out,
  output logic [SZ_W-1:0]  mtu_in
);
  localparam logic [VER_W-1:0] LO_V = VER_W'(VER_MIN);
  localparam logic [VER_W-1:0] HI_V = VER_W'(VER_MAX);
  localparam logic [VER_W-1:0] V2   = VER_W'(2);
  localparam logic [SZ_W-1:0]  SZ_BTU = SZ_W'(BTU);
  localparam logic [SZ_W-1:0]  SZ_BUF = SZ_W'(BUF_SIZE);

  logic [VER_W-1:0] lo, hi;

  always_comb begin
    lo  = (host_vmin > LO_V) ? host_vmin : LO_V;
    hi  = (host_vmax < HI_V) ? host_vmax : HI_V;
    ok  = (lo <= hi);
    ver = ok ? hi : '0;
    if (ok && ver >= V2) begin
      mtu_in = SZ_BUF;
      if (host_rx_sz < SZ_BTU)      mtu_out = SZ_BTU;
      else if (host_rx_sz > SZ_BUF) mtu_out = SZ_BUF;
      else                          mtu_out = host_rx_sz;
    end else begin
      mtu_in  = SZ_BTU;
      mtu_out = SZ_BTU;
    end
  end

  always_comb begin
    a_r3_ver_in_range: assert (!ok || (ver >= LO_V && ver <= HI_V && ver >= host_vmin && ver <= host_vmax));
  end
endmodule

// File: rtl/pkt_crc32.sv
module pkt_crc32 #(
  parameter logic [31:0] POLY = 32'hEDB88320
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        vld,
  input  logic [7:0]  din,
  output logic [31:0] crc
);
  logic [31:0] rem_q, rem_d;

  always_comb begin
    logic [31:0] c;
    c = rem_q;
    if (clr) begin
      c = '1;
    end else if (vld) begin
      c = rem_q ^ {24'h0, din};
      for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
    end
    rem_d = c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rem_q <= '1;
    else if (clr || vld)  rem_q <= rem_d;
  end

  assign crc = ~rem_q;

  a_r11_seed: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (crc == 32'h0));
endmodule

// File: rtl/pkt_chan_seq.sv
module pkt_chan_seq
  import pkt_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       obf,
  input  logic       set_stat,
  input  logic [7:0] stat_val,
  input  logic       set_rxc,
  input  logic       set_txb,
  output logic       str_we,
  output logic [7:0] str_data,
  output logic       odr_we,
  output logic [7:0] odr_data
);
  logic pend_stat_q, pend_rxc_q, pend_txb_q, dummy_q, guard_q;
  logic pend_stat_d, pend_rxc_d, pend_txb_d, dummy_d, guard_d;
  logic str_we_d, odr_we_d;
  logic [7:0] str_data_d, odr_data_d;
  logic can_go;

  always_comb begin
    can_go      = !obf && !guard_q && !dummy_q;
    pend_stat_d = pend_stat_q | set_stat;
    pend_rxc_d  = pend_rxc_q | set_rxc;
    pend_txb_d  = pend_txb_q | set_txb;
    dummy_d     = 1'b0;
    str_we_d    = 1'b0;
    odr_we_d    = 1'b0;
    str_data_d  = str_data;
    odr_data_d  = odr_data;
    if (dummy_q) begin
      odr_we_d   = 1'b1;
      odr_data_d = CMD_DUMMY;
    end else if (can_go && pend_stat_q) begin
      str_we_d    = 1'b1;
      str_data_d  = stat_val;
      dummy_d     = 1'b1;
      pend_stat_d = set_stat;
    end else if (can_go && pend_rxc_q) begin
      odr_we_d   = 1'b1;
      odr_data_d = CMD_RXCMP;
      pend_rxc_d = set_rxc;
    end else if (can_go && pend_txb_q) begin
      odr_we_d   = 1'b1;
      odr_data_d = CMD_TXBEG;
      pend_txb_d = set_txb;
    end
    guard_d = odr_we_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_stat_q <= 1'b0;
      pend_rxc_q  <= 1'b0;
      pend_txb_q  <= 1'b0;
      dummy_q     <= 1'b0;
      guard_q     <= 1'b0;
      str_we      <= 1'b0;
      odr_we      <= 1'b0;
      str_data    <= '0;
      odr_data    <= '0;
    end else begin
      pend_stat_q <= pend_stat_d;
      pend_rxc_q  <= pend_rxc_d;
      pend_txb_q  <= pend_txb_d;
      dummy_q     <= dummy_d;
      guard_q     <= guard_d;
      str_we      <= str_we_d;
      odr_we      <= odr_we_d;
      str_data    <= str_data_d;
      odr_data    <= odr_data_d;
    end
  end

  a_r8_spaced:    assert property (@(posedge clk) disable iff (!rst_n) odr_we |=> !odr_we);
  a_r9_filler:    assert property (@(posedge clk) disable iff (!rst_n) str_we |=> (odr_we && odr_data == CMD_DUMMY));
  a_r12_rxc_first: assert property (@(posedge clk) disable iff (!rst_n)
                     (odr_we && odr_data == CMD_TXBEG) |-> !$past(pend_rxc_q));
endmodule

// File: rtl/pkt_chan_ctrl.sv
module pkt_chan_ctrl
  import pkt_chan_pkg::*;
#(
  parameter int VER_W    = 4,
  parameter int VER_MIN  = 1,
  parameter int VER_MAX  = 3,
  parameter int SZ_W     = 16,
  parameter int BTU      = 64,
  parameter int BUF_SIZE = 256,
  parameter int CRC_VER  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             area_ready,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_byte,
  input  logic [VER_W-1:0] host_vmin,
  input  logic [VER_W-1:0] host_vmax,
  input  logic [SZ_W-1:0]  host_rx_sz,
  input  logic             obf,
  input  logic             tx_req,
  input  logic             tx_filled,
  input  logic             rx_done,
  input  logic             rx_byte_vld,
  input  logic [7:0]       rx_byte,
  input  logic [31:0]      rx_crc,
  output logic             str_we,
  output logic [7:0]       str_data,
  output logic             odr_we,
  output logic [7:0]       odr_data,
  output logic [VER_W-1:0] neg_ver,
  output logic [SZ_W-1:0]  mtu_to_host,
  output logic [SZ_W-1:0]  mtu_from_host,
  output logic             rx_own,
  output logic             tx_own,
  output logic             proto_err,
  output logic             crc_fail
);
  localparam logic [VER_W-1:0] CRC_V = VER_W'(CRC_VER);

  ch_state_e st_q, st_d;
  logic [VER_W-1:0] ver_d;
  logic [SZ_W-1:0]  mto_d, mfrom_d;
  logic rx_own_d, tx_own_d, holds_q, holds_d, err_d, crcf_d;
  logic set_stat, set_rxc, set_txb, crc_clr;
  logic ng_ok;
  logic [VER_W-1:0] ng_ver;
  logic [SZ_W-1:0]  ng_out, ng_in;
  logic [31:0] crc_now;
  logic [7:0]  stat_val;

  pkt_chan_vneg #(.VER_W(VER_W), .VER_MIN(VER_MIN), .VER_MAX(VER_MAX),
                  .SZ_W(SZ_W), .BTU(BTU), .BUF_SIZE(BUF_SIZE)) u_vneg (
    .host_vmin(host_vmin), .host_vmax(host_vmax), .host_rx_sz(host_rx_sz),
    .ok(ng_ok), .ver(ng_ver), .mtu_out(ng_out), .mtu_in(ng_in));

  pkt_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .vld(rx_byte_vld && rx_own),
    .din(rx_byte), .crc(crc_now));

  always_comb begin
    stat_val = '0;
    stat_val[STAT_CTL_BIT]  = (st_q != ST_OFF);
    stat_val[STAT_CHAN_BIT] = (st_q == ST_RUN);
  end

  pkt_chan_seq u_seq (
    .clk(clk), .rst_n(rst_n), .obf(obf), .set_stat(set_stat), .stat_val(stat_val),
    .set_rxc(set_rxc), .set_txb(set_txb), .str_we(str_we), .str_data(str_data),
    .odr_we(odr_we), .odr_data(odr_data));

  always_comb begin
    st_d = st_q; ver_d = neg_ver; mto_d = mtu_to_host; mfrom_d = mtu_from_host;
    rx_own_d = rx_own; tx_own_d = tx_own; holds_d = holds_q;
    err_d = proto_err; crcf_d = crc_fail;
    set_stat = 1'b0; set_rxc = 1'b0; set_txb = 1'b0; crc_clr = 1'b0;

    if (st_q == ST_OFF && area_ready) begin
      st_d = ST_WAIT;
      set_stat = 1'b1;
    end

    if (cmd_valid) begin
      unique case (cmd_byte)
        CMD_INIT: begin
          if (st_q == ST_OFF) err_d = 1'b1;
          else if (ng_ok) begin
            st_d = ST_RUN; ver_d = ng_ver; mto_d = ng_out; mfrom_d = ng_in;
            set_stat = 1'b1;
          end else begin
            st_d = ST_WAIT; ver_d = '0;
            set_stat = (st_q == ST_RUN);
          end
        end
        CMD_TXBEG: begin
          if (st_q != ST_RUN || rx_own) err_d = 1'b1;
          else begin
            rx_own_d = 1'b1; crc_clr = 1'b1; crcf_d = 1'b0;
          end
        end
        CMD_RXCMP: begin
          if (st_q != ST_RUN || !holds_q) err_d = 1'b1;
          else holds_d = 1'b0;
        end
        CMD_DUMMY: ;
        default: err_d = 1'b1;
      endcase
    end

    if (rx_done && rx_own) begin
      rx_own_d = 1'b0;
      set_rxc  = 1'b1;
      crcf_d   = (neg_ver == CRC_V) && (crc_now != rx_crc);
    end

    if (tx_filled && tx_own) begin
      tx_own_d = 1'b0;
      holds_d  = 1'b1;
      set_txb  = 1'b1;
    end else if (st_q == ST_RUN && tx_req && !tx_own && !holds_q) begin
      tx_own_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= ST_OFF;
      neg_ver       <= '0;
      mtu_to_host   <= '0;
      mtu_from_host <= '0;
      rx_own        <= 1'b0;
      tx_own        <= 1'b0;
      holds_q       <= 1'b0;
      proto_err     <= 1'b0;
      crc_fail      <= 1'b0;
    end else begin
      st_q          <= st_d;
      neg_ver       <= ver_d;
      mtu_to_host   <= mto_d;
      mtu_from_host <= mfrom_d;
      rx_own        <= rx_own_d;
      tx_own        <= tx_own_d;
      holds_q       <= holds_d;
      proto_err     <= err_d;
      crc_fail      <= crcf_d;
    end
  end

  a_r10_sticky:    assert property (@(posedge clk) disable iff (!rst_n) proto_err |=> proto_err);
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n) tx_own |-> !holds_q);
  a_r8_obf_block:  assert property (@(posedge clk) disable iff (!rst_n)
                     (odr_we && !$past(str_we)) |-> !$past(obf));
  a_r6_release:    assert property (@(posedge clk) disable iff (!rst_n)
                     (rx_own && rx_done) |=> !rx_own);
endmodule

// File: tb/test_pkt_chan_ctrl.sv
module test_pkt_chan_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic area_ready = 1'b0, cmd_valid = 1'b0, tx_req = 1'b0, tx_filled = 1'b0;
  logic rx_done = 1'b0, rx_byte_vld = 1'b0;
  logic [7:0] cmd_byte = '0, rx_byte = '0;
  logic [3:0] host_vmin = 4'd1, host_vmax = 4'd1;
  logic [15:0] host_rx_sz = 16'd64;
  logic [31:0] rx_crc = '0;
  logic obf_q = 1'b0, obf_force = 1'b0, obf;
  logic str_we, odr_we, rx_own, tx_own, proto_err, crc_fail;
  logic [7:0] str_data, odr_data;
  logic [3:0] neg_ver;
  logic [15:0] mtu_to_host, mtu_from_host;
  int nchk = 0, nerr = 0, lcnt = 0;
  logic [8:0] lg [64];

  assign obf = obf_q | obf_force;
  always #10 clk = ~clk;

  pkt_chan_ctrl i_pkt_chan_ctrl (.*);

  always @(posedge clk) begin
    if (!rst_n) obf_q <= 1'b0;
    else if (odr_we) obf_q <= 1'b1;
    else obf_q <= 1'b0;
  end

  always @(posedge clk) if (rst_n) begin
    if (str_we && lcnt < 64) begin lg[lcnt] = {1'b1, str_data}; lcnt++; end
    if (odr_we && lcnt < 64) begin lg[lcnt] = {1'b0, odr_data}; lcnt++; end
  end

  // {vmin, vmax, host rx size, expected version, expected to-host, expected from-host}
  localparam logic [59:0] VEC [6] = '{
    {4'd1, 4'd1, 16'd500, 4'd1, 16'd64,  16'd64},
    {4'd1, 4'd2, 16'd100, 4'd2, 16'd100, 16'd256},
    {4'd2, 4'd5, 16'd500, 4'd3, 16'd256, 16'd256},
    {4'd3, 4'd3, 16'd10,  4'd3, 16'd64,  16'd256},
    {4'd4, 4'd6, 16'd100, 4'd0, 16'd0,   16'd0},
    {4'd2, 4'd1, 16'd100, 4'd0, 16'd0,   16'd0}
  };

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); cmd_valid = 1'b1; cmd_byte = b;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0; area_ready = 1'b0; tx_req = 1'b0;
    obf_force = 1'b0; cyc(2); lcnt = 0; rst_n = 1'b1;
  endtask

  task automatic bring_up(input logic [3:0] vmin, input logic [3:0] vmax, input logic [15:0] rsz);
    host_vmin = vmin; host_vmax = vmax; host_rx_sz = rsz;
    do_reset(); area_ready = 1'b1; cyc(8);
    send(8'h00); cyc(8);
  endtask

  task automatic stream_digits;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); rx_byte_vld = 1'b1; rx_byte = 8'h31 + 8'(i);
    end
    @(negedge clk); rx_byte_vld = 1'b0;
  endtask

  task automatic pulse_rx_done;
    @(negedge clk); rx_done = 1'b1; @(negedge clk); rx_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int base;
    // R1 reset state
    do_reset(); cyc(1);
    chk(!str_we && !odr_we && !rx_own && !tx_own && !proto_err && !crc_fail && neg_ver == 0,
        "R1 reset outputs", {str_we, odr_we, rx_own, tx_own, proto_err, crc_fail}, 0);

    // R3 R4 R5 R2 R9 table walk
    for (int k = 0; k < 6; k++) begin
      logic [59:0] v;
      v = VEC[k];
      bring_up(v[59:56], v[55:52], v[51:36]);
      chk(lcnt >= 2 && lg[0] == 9'h180 && lg[1] == 9'h0FF, "R2 R9 active status then filler",
          {lg[0], lg[1]}, {9'h180, 9'h0FF});
      chk(neg_ver == v[35:32], "R3 R4 negotiated version", neg_ver, v[35:32]);
      if (v[35:32] != 0) begin
        chk(lcnt == 4 && lg[2] == 9'h1C0 && lg[3] == 9'h0FF, "R3 live status then filler",
            {lg[2], lg[3]}, {9'h1C0, 9'h0FF});
        chk(mtu_to_host == v[31:16] && mtu_from_host == v[15:0], "R5 sizes",
            {mtu_to_host, mtu_from_host}, v[31:0]);
      end else begin
        chk(lcnt == 2, "R4 no status update without common version", lcnt, 2);
      end
    end

    // R10 early commands
    host_vmin = 1; host_vmax = 3; do_reset(); cyc(2);
    send(8'h00); cyc(2);
    chk(proto_err == 1'b1, "R10 init before area ready", proto_err, 1);
    do_reset(); area_ready = 1'b1; cyc(8);
    send(8'hFF); cyc(2);
    chk(proto_err == 1'b0, "R10 filler from host ignored", proto_err, 0);
    send(8'h01); cyc(4);
    chk(proto_err == 1'b1 && rx_own == 1'b0 && lcnt == 2, "R10 tx begin before live",
        {proto_err, rx_own}, 2'b10);
    send(8'h00); cyc(8);
    chk(proto_err == 1'b1, "R10 error sticky", proto_err, 1);

    // R6 R11 receive path, good CRC
    bring_up(4'd3, 4'd3, 16'd256);
    send(8'h02); cyc(2);
    chk(proto_err == 1'b1, "R10 rx complete with nothing outstanding", proto_err, 1);
    bring_up(4'd3, 4'd3, 16'd256);
    send(8'h01); cyc(1);
    chk(rx_own == 1'b1, "R6 tx begin grants receive buffer", rx_own, 1);
    base = lcnt;
    stream_digits(); rx_crc = 32'hCBF43926; pulse_rx_done(); cyc(6);
    chk(rx_own == 1'b0 && lcnt == base + 1 && lg[base] == 9'h002, "R6 release sends rx complete",
        lg[base], 9'h002);
    chk(crc_fail == 1'b0, "R11 good crc accepted", crc_fail, 0);
    send(8'h01); stream_digits(); rx_crc = 32'hCBF43927; pulse_rx_done(); cyc(6);
    chk(crc_fail == 1'b1, "R11 bad crc flagged", crc_fail, 1);

    // R11 no check under version 2
    bring_up(4'd2, 4'd2, 16'd256);
    send(8'h01); stream_digits(); rx_crc = 32'h0; pulse_rx_done(); cyc(6);
    chk(crc_fail == 1'b0, "R11 no crc check in version 2", crc_fail, 0);

    // R7 transmit path
    bring_up(4'd2, 4'd3, 16'd128);
    @(negedge clk); tx_req = 1'b1; cyc(1);
    chk(tx_own == 1'b1, "R7 grant on request", tx_own, 1);
    base = lcnt;
    @(negedge clk); tx_filled = 1'b1; @(negedge clk); tx_filled = 1'b0; cyc(6);
    chk(tx_own == 1'b0 && lcnt == base + 1 && lg[base] == 9'h001, "R7 tx begin sent",
        lg[base], 9'h001);
    cyc(4);
    chk(tx_own == 1'b0, "R7 no grant while host holds buffer", tx_own, 0);
    send(8'h02); cyc(1);
    chk(tx_own == 1'b1 && proto_err == 1'b0, "R7 grant after rx complete", tx_own, 1);

    // R8 R12 same-cycle hand-offs behind a full data register
    send(8'h01); cyc(1);
    base = lcnt;
    @(negedge clk); obf_force = 1'b1;
    send(8'h00);
    @(negedge clk); rx_done = 1'b1; tx_filled = 1'b1;
    @(negedge clk); rx_done = 1'b0; tx_filled = 1'b0;
    cyc(6);
    chk(lcnt == base, "R8 nothing written while obf high", lcnt - base, 0);
    @(negedge clk); obf_force = 1'b0; cyc(16);
    chk(lcnt == base + 4 && lg[base] == 9'h1C0 && lg[base+1] == 9'h0FF &&
        lg[base+2] == 9'h002 && lg[base+3] == 9'h001, "R12 order status, rx complete, tx begin",
        {lg[base], lg[base+1], lg[base+2], lg[base+3]}, {9'h1C0, 9'h0FF, 9'h002, 9'h001});
    tx_req = 1'b0;

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule